// File: doc/BRIEF.md
# Masked Lane Reduction Unit

This unit collapses a wide vector of lanes into a single scalar for a thread-interleaved controller. It takes 128 lanes of 16-bit data and a select bit per lane. It combines the selected lanes with one of three operations: bitwise OR, signed maximum or wrap-around sum. The result comes back after a fixed number of cycles. The work is done in a fully registered binary tree. Extra delay registers pad the tree up to the configured latency.

Only one request can be in flight at a time. The issuing thread is expected to stall until its result returns. The thread identifier that arrives with a request goes out again with the result, so the scheduler knows which thread to wake up.

Requests use a valid/ready handshake. `in_ready` is high only while the unit is idle. A request is accepted in any cycle where `in_valid` and `in_ready` are both high. While the unit is busy, a held-up `in_valid` simply waits. The result side has no ready signal: `out_valid` is a one-cycle pulse and the consumer must take the result in that cycle.

Top module: `lane_reduce_unit`

## Requirements
- R1: A request is accepted only in a cycle where `in_valid` and `in_ready` are both high. An `in_valid` presented while `in_ready` is low has no effect on the result, the tag, the timing, or the number of results produced.
- R2: If a request is accepted in cycle t, `out_valid` is high in cycle t+10 and only in that cycle, for exactly one cycle.
- R3: `busy` is high from cycle t+1 through cycle t+10 inclusive and low otherwise. `in_ready` is the inverse of `busy`.
- R4: While `out_valid` is high, `out_tag` equals the `in_tag` value captured at acceptance.
- R5: When `in_op` is 0, `out_result` is the bitwise OR of the selected lanes.
- R6: When `in_op` is 1, `out_result` is the largest selected lane, with lanes read as signed two's-complement 16-bit values.
- R7: When `in_op` is 2, `out_result` is the sum of the selected lanes, modulo 2^16.
- R8: Bit i of `in_mask` selects lane i, whose data is `in_data[16*i+15:16*i]`. A deselected lane never affects the result. If no lane is selected, the result is 0x0000 for OR and sum, and 0x8000 for maximum.
- R9: When `in_op` is 3, the unit behaves exactly as for code 0 (OR).
- R10: During and right after reset, `busy` and `out_valid` are low and `in_ready` is high.
- R11: A new request presented in the cycle right after a result pulse is accepted, and it completes with its own correct timing and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit idle; a request can be accepted |
| in_data | input | 2048 | Lane data; lane i occupies bits 16*i+15 down to 16*i |
| in_mask | input | 128 | Lane select; bit i selects lane i |
| in_op | input | 2 | Operation: 0 OR, 1 signed max, 2 sum, 3 same as OR |
| in_tag | input | 2 | Thread identifier of the requester |
| out_valid | output | 1 | One-cycle result pulse |
| out_result | output | 16 | Reduced scalar; meaningful while out_valid is high |
| out_tag | output | 2 | Thread identifier of the completed request |
| busy | output | 1 | A reduction is in flight |

## Verification
The bench targets the cases where a shortcut design would give itself away.

- Maximum is checked on lanes that mix signs. A design using unsigned comparison would report a negative lane, such as 0x8001, as the winner.
- Sum is checked on 128 lanes of 0xFFFF, which must wrap to 0xFF80. A saturating or miswired adder would return something else.
- An empty mask must give the identity value of each operation. A design that passed zero into a maximum would return 0x0000 instead of 0x8000.
- A mask that deselects lanes larger than the chosen lane must leave them out. A design that ignored the mask would return the larger value.
- A second request is driven while the unit is busy. A design that accepted it would corrupt the tag or result, or emit an extra pulse.
- A request is issued back to back, straight after a result. A design with an off-by-one busy window would drop it or report the wrong cycle.

// File: rtl/lane_reduce_pkg.sv
package lane_reduce_pkg;

  typedef enum logic [1:0] {
    RED_OR  = 2'd0,
    RED_MAX = 2'd1,
    RED_SUM = 2'd2,
    RED_ALT = 2'd3
  } red_op_e;

  // Code 3 is folded onto OR so that downstream logic only sees three cases.
  function automatic red_op_e canon_op(input logic [1:0] code);
    if (code == 2'd3) return RED_OR;
    return red_op_e'(code);
  endfunction

endpackage

// File: rtl/lane_reduce_ctrl.sv
module lane_reduce_ctrl
  import lane_reduce_pkg::*;
#(
  parameter int LATENCY = 10,
  parameter int TW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [TW-1:0] in_tag,
  output logic          in_ready,
  output logic          accept,
  output red_op_e       op_q,
  output logic [TW-1:0] tag_q,
  output logic          busy,
  output logic          done
);

  localparam int CW = $clog2(LATENCY + 1);

  // Cycles left until the result leaves; zero means idle.
  logic [CW-1:0] left_q;

  assign busy     = (left_q != '0);
  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;
  assign done     = (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      op_q   <= RED_OR;
      tag_q  <= '0;
    end else if (accept) begin
      left_q <= CW'(LATENCY);
      op_q   <= canon_op(in_op);
      tag_q  <= in_tag;
    end else if (busy) begin
      left_q <= left_q - CW'(1);
    end
  end

endmodule

// File: rtl/lane_reduce_prep.sv
module lane_reduce_prep
  import lane_reduce_pkg::*;
#(
  parameter int LANES = 128,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                load,
  input  red_op_e             op,
  input  logic [LANES*DW-1:0] data,
  input  logic [LANES-1:0]    mask,
  output logic [LANES*DW-1:0] lanes_q
);

  localparam logic [DW-1:0] MAX_IDENT = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0]       ident;
  logic [LANES*DW-1:0] sel;

  // Identity of the chosen operation: most negative value for max, else zero.
  always_comb ident = (op == RED_MAX) ? MAX_IDENT : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sel[i*DW +: DW] = mask[i] ? data[i*DW +: DW] : ident;
  end

  always_ff @(posedge clk) begin
    if (load) lanes_q <= sel;
  end

endmodule

// File: rtl/lane_reduce_level.sv
module lane_reduce_level
  import lane_reduce_pkg::*;
#(
  parameter int IN_N = 128,
  parameter int DW   = 16
) (
  input  logic                   clk,
  input  red_op_e                op,
  input  logic [IN_N*DW-1:0]     din,
  output logic [(IN_N/2)*DW-1:0] dout_q
);

  localparam int OUT_N = IN_N / 2;

  function automatic logic [DW-1:0] merge(input red_op_e o,
                                          input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    case (o)
      RED_MAX: return ($signed(a) > $signed(b)) ? a : b;
      RED_SUM: return a + b;
      default: return a | b;
    endcase
  endfunction

  logic [OUT_N*DW-1:0] nxt;

  for (genvar j = 0; j < OUT_N; j++) begin : g_pair
    assign nxt[j*DW +: DW] = merge(op, din[(2*j)*DW +: DW], din[(2*j+1)*DW +: DW]);
  end

  always_ff @(posedge clk) dout_q <= nxt;

endmodule

// File: rtl/lane_reduce_unit.sv
module lane_reduce_unit
  import lane_reduce_pkg::*;
#(
  parameter int LANES   = 128,
  parameter int DW      = 16,
  parameter int TW      = 2,
  parameter int LATENCY = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES-1:0]    in_mask,
  input  logic [1:0]          in_op,
  input  logic [TW-1:0]       in_tag,
  output logic                out_valid,
  output logic [DW-1:0]       out_result,
  output logic [TW-1:0]       out_tag,
  output logic                busy
);

  localparam int LEVELS = $clog2(LANES);
  // Registers after the tree root needed to reach the latency: one goes to
  // lane preparation, LEVELS to the tree, and the rest to padding.
  localparam int PAD    = LATENCY - 1 - LEVELS;
  localparam int ROOT   = 2*LANES - 2;

  logic    accept;
  red_op_e op_q;
  red_op_e in_op_c;
  logic [TW-1:0] tag_q;
  logic    done;
  logic [LANES*DW-1:0] prep_q;

  assign in_op_c = canon_op(in_op);

  lane_reduce_ctrl #(.LATENCY(LATENCY), .TW(TW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (in_op),
    .in_tag   (in_tag),
    .in_ready (in_ready),
    .accept   (accept),
    .op_q     (op_q),
    .tag_q    (tag_q),
    .busy     (busy),
    .done     (done)
  );

  lane_reduce_prep #(.LANES(LANES), .DW(DW)) u_prep (
    .clk     (clk),
    .load    (accept),
    .op      (in_op_c),
    .data    (in_data),
    .mask    (in_mask),
    .lanes_q (prep_q)
  );

  // All tree nodes in one flat bus: the level holding N nodes starts at
  // element 2*LANES - 2*N.
  wire [(2*LANES-1)*DW-1:0] tree_w;
  assign tree_w[LANES*DW-1:0] = prep_q;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int N       = LANES >> l;
    localparam int OFF_IN  = 2*LANES - 2*N;
    localparam int OFF_OUT = OFF_IN + N;
    lane_reduce_level #(.IN_N(N), .DW(DW)) u_lvl (
      .clk    (clk),
      .op     (op_q),
      .din    (tree_w[OFF_IN*DW +: N*DW]),
      .dout_q (tree_w[OFF_OUT*DW +: (N/2)*DW])
    );
  end

  logic [DW-1:0] pad_q [PAD];

  always_ff @(posedge clk) begin
    pad_q[0] <= tree_w[ROOT*DW +: DW];
    for (int p = 1; p < PAD; p++) pad_q[p] <= pad_q[p-1];
  end

  assign out_result = pad_q[PAD-1];
  assign out_valid  = done;
  assign out_tag    = tag_q;

endmodule

// File: rtl/lane_reduce_chk.sv
module lane_reduce_chk #(
  parameter int LATENCY = 10,
  parameter int TW      = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [TW-1:0] in_tag,
  input logic          busy,
  input logic          out_valid,
  input logic [TW-1:0] out_tag
);

  localparam int SW = $clog2(LATENCY + 2);

  logic [SW-1:0] since_q;
  logic [TW-1:0] tag_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      tag_cap <= '0;
    end else if (in_valid && in_ready) begin
      since_q <= SW'(1);
      tag_cap <= in_tag;
    end else if (since_q != '0 && since_q <= SW'(LATENCY)) begin
      since_q <= since_q + SW'(1);
    end
  end

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_q == SW'(LATENCY)));

  assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid));

  assert_pulse_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  assert_tag_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tag == tag_cap));

  assert_tag_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(out_tag));

endmodule

bind lane_reduce_unit lane_reduce_chk #(.LATENCY(LATENCY), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_tag    (in_tag),
  .busy      (busy),
  .out_valid (out_valid),
  .out_tag   (out_tag)
);

// File: tb/lane_reduce_unit_tb_top.sv
module lane_reduce_unit_tb_top;

  localparam int LANES      = 128;
  localparam int DW         = 16;
  localparam int TW         = 2;
  localparam int LATENCY    = 10;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 12;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES*DW-1:0] in_data = '0;
  logic [LANES-1:0]    in_mask = '0;
  logic [1:0]          in_op = '0;
  logic [TW-1:0]       in_tag = '0;
  logic                out_valid;
  logic [DW-1:0]       out_result;
  logic [TW-1:0]       out_tag;
  logic                busy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_reduce_unit #(.LANES(LANES), .DW(DW), .TW(TW), .LATENCY(LATENCY)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mask(in_mask), .in_op(in_op), .in_tag(in_tag),
    .out_valid(out_valid), .out_result(out_result), .out_tag(out_tag), .busy(busy)
  );

  // Vector fields: op[24:23] data_kind[22:21] seed[20:5] mask_kind[4:2] tag[1:0]
  localparam logic [24:0] VEC [NVEC] = '{
    {2'd0, 2'd2, 16'h0000, 3'd0, 2'd0},  // R5 one-hot bits, OR to FFFF
    {2'd0, 2'd0, 16'h1234, 3'd2, 2'd1},  // R8 even lanes
    {2'd1, 2'd0, 16'h0309, 3'd0, 2'd2},  // R6
    {2'd1, 2'd3, 16'h0005, 3'd0, 2'd3},  // R6 mixed signs
    {2'd1, 2'd3, 16'h0005, 3'd1, 2'd0},  // R8 empty mask max -> 8000
    {2'd2, 2'd1, 16'h0000, 3'd0, 2'd1},  // R7 wrap to FF80
    {2'd2, 2'd0, 16'h10E1, 3'd4, 2'd2},  // R8 low half
    {2'd2, 2'd0, 16'h0063, 3'd1, 2'd3},  // R8 empty sum -> 0
    {2'd0, 2'd1, 16'h0000, 3'd1, 2'd0},  // R8 empty OR -> 0
    {2'd3, 2'd0, 16'h022B, 3'd0, 2'd1},  // R9 code 3 as OR
    {2'd1, 2'd3, 16'h0009, 3'd3, 2'd2},  // R8 only lane 127
    {2'd2, 2'd3, 16'h0003, 3'd2, 2'd3}   // R8 sum over even lanes
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [LANES*DW-1:0] gen_data(input int kind, input logic [15:0] seed);
    logic [LANES*DW-1:0] d;
    d = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [15:0] v;
      case (kind)
        0: v = 16'(seed + i*40503) ^ 16'(i << 3);
        1: v = 16'hFFFF;
        2: v = 16'(1 << (i % 16));
        default: v = (i % 2 == 1) ? 16'(-(i + int'(seed))) : 16'(i*3);
      endcase
      d[i*DW +: DW] = v;
    end
    return d;
  endfunction

  function automatic logic [LANES-1:0] gen_mask(input int kind);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) begin
      case (kind)
        0: m[i] = 1'b1;
        1: m[i] = 1'b0;
        2: m[i] = (i % 2 == 0);
        3: m[i] = (i == LANES-1);
        default: m[i] = (i < LANES/2);
      endcase
    end
    return m;
  endfunction

  // Reference built from the requirements (R5..R9).
  function automatic logic [15:0] model(input logic [1:0] op, input logic [LANES*DW-1:0] d,
                                        input logic [LANES-1:0] m);
    int          sum;
    int          best;
    logic [15:0] orv;
    sum = 0; best = -32768; orv = '0;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        logic [15:0] v;
        v = d[i*DW +: DW];
        orv = orv | v;
        sum = sum + int'(v);
        if ($signed(v) > best) best = $signed(v);
      end
    end
    case (op)
      2'd1:    return 16'(best);
      2'd2:    return sum[15:0];
      default: return orv;
    endcase
  endfunction

  // Called at a negedge while idle; returns at the negedge after the pulse cycle.
  task automatic run_req(input logic [1:0] op, input logic [LANES*DW-1:0] d,
                         input logic [LANES-1:0] m, input logic [TW-1:0] tag, input string req);
    logic [15:0] exp;
    bit          quiet;
    exp = model(op, d, m);
    check(in_ready == 1'b1, "R1", "ready before request", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_op = op; in_data = d; in_mask = m; in_tag = tag;
    @(negedge clk);
    in_valid = 1'b0;
    quiet = 1'b1;
    for (int n = 1; n < LATENCY; n++) begin
      if (out_valid !== 1'b0 || busy !== 1'b1 || in_ready !== 1'b0) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R3", "busy window before pulse", 32'(quiet), 32'd1);
    check(out_valid == 1'b1, "R2", "pulse at latency", 32'(out_valid), 32'd1);
    check(out_result == exp, req, "result", 32'(out_result), 32'(exp));
    check(out_tag == tag, "R4", "tag", 32'(out_tag), 32'(tag));
    @(negedge clk);
    check(out_valid == 1'b0 && busy == 1'b0 && in_ready == 1'b1, "R2",
          "idle after pulse", {29'd0, out_valid, busy, in_ready}, 32'b001);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [LANES*DW-1:0] d;
    logic [LANES-1:0]    m;
    int                  extra;

    // R10 reset state
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0 && in_ready == 1'b1, "R10", "in reset",
          {29'd0, busy, out_valid, in_ready}, 32'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0 && in_ready == 1'b1, "R10", "after reset",
          {29'd0, busy, out_valid, in_ready}, 32'b001);

    // Table walk: R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [24:0] e;
      string       req;
      e = VEC[v];
      if (e[4:2] != 3'd0)       req = "R8";
      else if (e[24:23] == 2'd0) req = "R5";
      else if (e[24:23] == 2'd1) req = "R6";
      else if (e[24:23] == 2'd2) req = "R7";
      else                       req = "R9";
      run_req(e[24:23], gen_data(int'(e[22:21]), e[20:5]), gen_mask(int'(e[4:2])), e[1:0], req);
    end

    // R6 signed comparison: -32767 against +2
    d = '0; m = '0;
    d[0*DW +: DW] = 16'h8001; d[1*DW +: DW] = 16'h0002;
    m[0] = 1'b1; m[1] = 1'b1;
    run_req(2'd1, d, m, 2'd1, "R6");

    // R8 larger deselected lanes must not win
    d = '0;
    for (int i = 0; i < LANES; i++) d[i*DW +: DW] = 16'h7FFF;
    d[5*DW +: DW] = 16'h0001;
    m = '0; m[5] = 1'b1;
    run_req(2'd1, d, m, 2'd2, "R8");

    // R11 back-to-back: second request in the cycle right after the pulse
    run_req(2'd2, gen_data(0, 16'h0abc), gen_mask(0), 2'd3, "R11");
    run_req(2'd0, gen_data(3, 16'h0007), gen_mask(4), 2'd0, "R11");

    // R1 request while busy is ignored
    d = gen_data(0, 16'h0042);
    in_valid = 1'b1; in_op = 2'd0; in_data = d; in_mask = gen_mask(2); in_tag = 2'd1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "ready low while busy", 32'(in_ready), 32'd0);
    in_valid = 1'b1; in_op = 2'd2; in_data = gen_data(1, 16'h0); in_mask = gen_mask(0); in_tag = 2'd2;
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 4; n < LATENCY; n++) @(negedge clk);
    check(out_valid == 1'b1, "R1", "original pulse timing", 32'(out_valid), 32'd1);
    check(out_result == model(2'd0, d, gen_mask(2)), "R1", "original result",
          32'(out_result), 32'(model(2'd0, d, gen_mask(2))));
    check(out_tag == 2'd1, "R1", "original tag", 32'(out_tag), 32'd1);
    extra = 0;
    for (int n = 0; n < 15; n++) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    check(extra == 0 && busy == 1'b0, "R1", "no second pulse", 32'(extra), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule